// File: doc/BRIEF.md
# Multi-Channel Thermal Threshold Monitor

This block watches up to seven temperature-sensor channels. Each channel presents a raw conversion code on a sample port that stands in for the analog converter. While automatic scanning is on, a sequencer waits one scan interval and then visits the channels in ascending index order, one per clock cycle. On its visit, each enabled channel latches its current code into a readable data register. The code is then compared against two programmable limits: an alarm threshold and a shutdown threshold. Codes rise with temperature, and a code equal to a limit counts as over that limit.

A limit takes effect only after a programmable run of consecutive over-limit samples. Any sample below the limit restarts that run. When the alarm run completes, the channel's pending bit is set, and a maskable interrupt is raised from it. When the shutdown run completes, the channel's shutdown is latched until reset. A latched shutdown is routed, per channel, to a GPIO shutdown pin with programmable polarity, to a clock/reset shutdown request, or to both. Once any channel has reached its alarm limit, the sequencer switches to a second, usually shorter, scan interval.

Software reaches the block through a simple 32-bit register bus. Reads return data one cycle after the read cycle. The enable and control registers use a write mask held in the upper half of the write data.

Top module: `therm_mon`

## Requirements
- R1: After reset, the following values hold.
  - The control register (0x000) and the pending register (0x014) read 0.
  - The alarm debounce register (0x018) and the shutdown debounce register (0x01C) read 4.
  - `irq` and `shut_req` are low, and `shut_gpio` is high.
- R2: Five registers are write-masked: control 0x000, source enable 0x004, interrupt enable 0x008, GPIO enable 0x00C and clock/reset enable 0x010. In each of them, data bit n (n < 16) takes write-data bit n only when write-data bit n+16 is 1; otherwise it keeps its value.
- R3: Control bit 0 turns scanning on. Scan timing works as follows.
  - With scanning on and an interval of P cycles (register 0x020), the sequencer idles P cycles and then samples channel c in the cycle P+1+c after the enabling edge.
  - After the last channel, it idles again.
  - A channel whose source-enable bit (bit c of 0x004) is 1 latches its code into data register 0x040+4c.
  - A disabled channel's data register does not change.
- R4: A sample counts as over the alarm limit when it is at or above the channel's alarm threshold (0x080+4c). Consecutive over samples are counted, and a below sample resets the count to zero. When the count reaches the alarm debounce value, bit c of the pending register is set; a debounce value of 0 acts as 1.
- R5: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A set bit stays set when later samples fall below the limit.
- R6: `irq` is high exactly when some pending bit is set and its bit in the interrupt enable register is also set.
- R7: A sample at or above the channel's shutdown threshold (0x0C0+4c) counts toward the shutdown debounce value (0x01C). A below sample resets the count. When the count reaches the debounce value, the channel's shutdown is latched until reset.
- R8: A latched shutdown drives `shut_gpio` active when the channel's GPIO enable bit is set. It drives `shut_req` high when the channel's clock/reset enable bit is set. The enables are applied continuously, so an enable set after the event still routes it.
- R9: Control bit 8 selects the polarity of `shut_gpio`. With 0 the pin is active-low and rests high; with 1 it is active-high and rests low.
- R10: Once any channel's latest sample is at or above its alarm threshold, the idle interval between rounds is taken from register 0x024 instead of 0x020.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data; the upper half is the mask for masked registers |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| samp_code | input | NCH*CW | Current conversion code of each channel, channel c at bits c*CW upward |
| irq | output | 1 | Alarm interrupt |
| shut_gpio | output | 1 | GPIO shutdown pin, polarity per control bit 8 |
| shut_req | output | 1 | Clock/reset shutdown request, active high |

## Verification
The hardest situation to reach from the ports is a debounce run that is broken in the middle. A channel has to be over its limit on some scan rounds and under it on exactly one round between them. Meanwhile, other channels must complete their runs on the same rounds. The stimulus gets there by turning scanning on for a counted number of rounds and then off again between rounds, so that sample codes can be changed while the sequencer is idle. The switch to the hot interval is checked by reading a data register just before and just after the instant at which the shortened interval places the next sample.

// File: rtl/therm_mon_pkg.sv
// Package: shared register offsets and the masked-write helper for the
// thermal monitor. Assumes word-aligned 12-bit byte addresses.
package therm_mon_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 12;

    localparam logic [AW-1:0] A_CTRL  = 12'h000;
    localparam logic [AW-1:0] A_SRC   = 12'h004;
    localparam logic [AW-1:0] A_IRQEN = 12'h008;
    localparam logic [AW-1:0] A_GPIO  = 12'h00C;
    localparam logic [AW-1:0] A_CRU   = 12'h010;
    localparam logic [AW-1:0] A_PEND  = 12'h014;
    localparam logic [AW-1:0] A_ADEB  = 12'h018;
    localparam logic [AW-1:0] A_SDEB  = 12'h01C;
    localparam logic [AW-1:0] A_PER   = 12'h020;
    localparam logic [AW-1:0] A_PERH  = 12'h024;

    // Per-channel register blocks, selected by address bits [11:6]
    localparam logic [5:0] BLK_DATA = 6'h01;
    localparam logic [5:0] BLK_ATHR = 6'h02;
    localparam logic [5:0] BLK_STHR = 6'h03;

    // Bits of the control register that are implemented
    localparam logic [15:0] CTRL_BITS = 16'h0101;

    // Masked update: data bit n follows wd[n] only where wd[n+16] is set
    function automatic logic [15:0] mask_upd(input logic [15:0] cur, input logic [31:0] wd);
        return (cur & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
    endfunction
endpackage

// File: rtl/therm_mon_regs.sv
// Register file: masked control/enable registers, W1C pending bits,
// debounce and period registers, per-channel thresholds and read mux.
// Assumes one access per strobe and NCH <= 16. Read data is registered.
module therm_mon_regs
    import therm_mon_pkg::*;
#(
    parameter int NCH     = 7,
    parameter int CW      = 12,
    parameter int PW      = 16,
    parameter int DBW     = 4,
    parameter int PER_RST = 1000,
    parameter int HOT_RST = 250
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_we,
    input  logic [AW-1:0]           bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [NCH-1:0][CW-1:0]  data_i,
    input  logic [NCH-1:0]          alm_set,
    output logic                    scan_en,
    output logic                    pol,
    output logic [NCH-1:0]          src_en,
    output logic [NCH-1:0]          irq_en,
    output logic [NCH-1:0]          gpio_en,
    output logic [NCH-1:0]          cru_en,
    output logic [NCH-1:0]          pend,
    output logic [DBW-1:0]          alm_deb,
    output logic [DBW-1:0]          shut_deb,
    output logic [PW-1:0]           period,
    output logic [PW-1:0]           period_hot,
    output logic [NCH-1:0][CW-1:0]  alm_thr,
    output logic [NCH-1:0][CW-1:0]  shut_thr
);
    localparam logic [15:0] CHMASK = 16'((32'd1 << NCH) - 1);

    logic        aligned, wr, rd, wr_pend;
    logic [3:0]  idx;
    logic [5:0]  blk;
    logic        idx_ok;
    logic [15:0] ctrl_q, src_q, irqen_q, gpio_q, cru_q;
    logic [NCH-1:0] pend_q;
    logic [31:0] rd_mux;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr      = bus_sel & bus_we & aligned;
    assign rd      = bus_sel & ~bus_we & aligned;
    assign wr_pend = wr && (bus_addr == A_PEND);
    assign idx     = bus_addr[5:2];
    assign blk     = bus_addr[11:6];
    assign idx_ok  = (32'(idx) < NCH);

    // Control, enable, debounce and period registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            src_q      <= '0;
            irqen_q    <= '0;
            gpio_q     <= '0;
            cru_q      <= '0;
            alm_deb    <= DBW'(4);
            shut_deb   <= DBW'(4);
            period     <= PW'(PER_RST);
            period_hot <= PW'(HOT_RST);
        end else if (wr) begin
            case (bus_addr)
                A_CTRL:  ctrl_q     <= mask_upd(ctrl_q, bus_wdata) & CTRL_BITS;
                A_SRC:   src_q      <= mask_upd(src_q, bus_wdata) & CHMASK;
                A_IRQEN: irqen_q    <= mask_upd(irqen_q, bus_wdata) & CHMASK;
                A_GPIO:  gpio_q     <= mask_upd(gpio_q, bus_wdata) & CHMASK;
                A_CRU:   cru_q      <= mask_upd(cru_q, bus_wdata) & CHMASK;
                A_ADEB:  alm_deb    <= bus_wdata[DBW-1:0];
                A_SDEB:  shut_deb   <= bus_wdata[DBW-1:0];
                A_PER:   period     <= bus_wdata[PW-1:0];
                A_PERH:  period_hot <= bus_wdata[PW-1:0];
                default: ;
            endcase
        end
    end

    // Per-channel alarm and shutdown thresholds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_thr  <= '1;
            shut_thr <= '1;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (wr && blk == BLK_ATHR && 32'(idx) == c) alm_thr[c]  <= bus_wdata[CW-1:0];
                if (wr && blk == BLK_STHR && 32'(idx) == c) shut_thr[c] <= bus_wdata[CW-1:0];
            end
        end
    end

    // Pending bits: write-one-to-clear, a new alarm event wins
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~(wr_pend ? bus_wdata[NCH-1:0] : '0)) | alm_set;
    end

    // Read data selection
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_CTRL:  rd_mux[15:0]     = ctrl_q;
            A_SRC:   rd_mux[15:0]     = src_q;
            A_IRQEN: rd_mux[15:0]     = irqen_q;
            A_GPIO:  rd_mux[15:0]     = gpio_q;
            A_CRU:   rd_mux[15:0]     = cru_q;
            A_PEND:  rd_mux[NCH-1:0]  = pend_q;
            A_ADEB:  rd_mux[DBW-1:0]  = alm_deb;
            A_SDEB:  rd_mux[DBW-1:0]  = shut_deb;
            A_PER:   rd_mux[PW-1:0]   = period;
            A_PERH:  rd_mux[PW-1:0]   = period_hot;
            default: begin
                for (int c = 0; c < NCH; c++) begin
                    if (idx_ok && 32'(idx) == c) begin
                        if (blk == BLK_DATA) rd_mux[CW-1:0] = data_i[c];
                        if (blk == BLK_ATHR) rd_mux[CW-1:0] = alm_thr[c];
                        if (blk == BLK_STHR) rd_mux[CW-1:0] = shut_thr[c];
                    end
                end
            end
        endcase
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_mux;
    end

    assign scan_en = ctrl_q[0];
    assign pol     = ctrl_q[8];
    assign src_en  = src_q[NCH-1:0];
    assign irq_en  = irqen_q[NCH-1:0];
    assign gpio_en = gpio_q[NCH-1:0];
    assign cru_en  = cru_q[NCH-1:0];
    assign pend    = pend_q;

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_CTRL && !bus_wdata[16]) |=> (ctrl_q[0] == $past(ctrl_q[0])));

    // R5
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pend_q) & ~pend_q)) |-> $past(wr_pend));
endmodule

// File: rtl/therm_mon_sched.sv
// Scan sequencer: counts the scan interval (normal or hot), then steps a
// slot index through channels 0..NCH-1, one per cycle. Assumes a
// period of 0 behaves as 1; turning scanning off returns to idle.
module therm_mon_sched #(
    parameter int NCH = 7,
    parameter int PW  = 16,
    localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_en,
    input  logic          hot,
    input  logic [PW-1:0] period,
    input  logic [PW-1:0] period_hot,
    output logic          active,
    output logic [SW-1:0] slot
);
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] cur;
    logic          expired;

    assign cur     = hot ? period_hot : period;
    assign expired = ((PW+1)'(cnt_q) + (PW+1)'(1)) >= (PW+1)'(cur);

    // Interval counter and slot stepping
    always_ff @(posedge clk) begin
        if (!rst_n || !scan_en) begin
            active <= 1'b0;
            slot   <= '0;
            cnt_q  <= '0;
        end else if (active) begin
            cnt_q <= '0;
            if (32'(slot) == NCH - 1) begin
                active <= 1'b0;
                slot   <= '0;
            end else begin
                slot <= slot + 1'b1;
            end
        end else if (expired) begin
            active <= 1'b1;
            slot   <= '0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (32'(slot) < NCH));
endmodule

// File: rtl/therm_mon_chan.sv
// One channel: latches the sample on its scan strobe, compares it with
// the alarm and shutdown limits, and counts consecutive over samples.
// Assumes a debounce value of 0 means 1; counters saturate.
module therm_mon_chan #(
    parameter int CW  = 12,
    parameter int DBW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stb,
    input  logic [CW-1:0]  code,
    input  logic [CW-1:0]  alm_thr,
    input  logic [CW-1:0]  shut_thr,
    input  logic [DBW-1:0] alm_deb,
    input  logic [DBW-1:0] shut_deb,
    output logic [CW-1:0]  data_q,
    output logic           alm_evt,
    output logic           over_alm,
    output logic           shut_hit
);
    logic           over_a, over_s;
    logic [DBW-1:0] a_cnt, s_cnt, a_next, s_next, a_eff, s_eff;
    logic           s_fire;

    assign over_a = (code >= alm_thr);
    assign over_s = (code >= shut_thr);
    assign a_next = over_a ? ((a_cnt == '1) ? a_cnt : a_cnt + 1'b1) : '0;
    assign s_next = over_s ? ((s_cnt == '1) ? s_cnt : s_cnt + 1'b1) : '0;
    assign a_eff  = (alm_deb  == '0) ? DBW'(1) : alm_deb;
    assign s_eff  = (shut_deb == '0) ? DBW'(1) : shut_deb;
    assign alm_evt = stb && over_a && (a_next >= a_eff);
    assign s_fire  = stb && over_s && (s_next >= s_eff);

    // Sample latch, debounce counters and sticky shutdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            a_cnt    <= '0;
            s_cnt    <= '0;
            over_alm <= 1'b0;
            shut_hit <= 1'b0;
        end else if (stb) begin
            data_q   <= code;
            a_cnt    <= a_next;
            s_cnt    <= s_next;
            over_alm <= over_a;
            if (s_fire) shut_hit <= 1'b1;
        end
    end

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(data_q));

    // R7
    shut_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shut_hit |=> shut_hit);
endmodule

// File: rtl/therm_mon.sv
// Top: multi-channel thermal threshold monitor. Joins the register file,
// the scan sequencer and one channel slice per sensor, and forms the
// interrupt and the two shutdown outputs. Assumes NCH <= 16.
module therm_mon
    import therm_mon_pkg::*;
#(
    parameter int NCH     = 7,
    parameter int CW      = 12,
    parameter int PW      = 16,
    parameter int DBW     = 4,
    parameter int PER_RST = 1000,
    parameter int HOT_RST = 250,
    localparam int SW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCH*CW-1:0] samp_code,
    output logic              irq,
    output logic              shut_gpio,
    output logic              shut_req
);
    logic [NCH-1:0][CW-1:0] data_q, alm_thr, shut_thr, codes;
    logic [NCH-1:0] alm_evt, over_alm, shut_hit, stb;
    logic [NCH-1:0] src_en, irq_en, gpio_en, cru_en, pend;
    logic [DBW-1:0] alm_deb, shut_deb;
    logic [PW-1:0]  period, period_hot;
    logic           scan_en, pol, active, gpio_act;
    logic [SW-1:0]  slot;

    assign codes = samp_code;

    therm_mon_regs #(.NCH(NCH), .CW(CW), .PW(PW), .DBW(DBW),
                     .PER_RST(PER_RST), .HOT_RST(HOT_RST)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .data_i(data_q), .alm_set(alm_evt), .scan_en(scan_en), .pol(pol),
        .src_en(src_en), .irq_en(irq_en), .gpio_en(gpio_en), .cru_en(cru_en),
        .pend(pend), .alm_deb(alm_deb), .shut_deb(shut_deb), .period(period),
        .period_hot(period_hot), .alm_thr(alm_thr), .shut_thr(shut_thr)
    );

    therm_mon_sched #(.NCH(NCH), .PW(PW)) sched_i (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .hot(|over_alm),
        .period(period), .period_hot(period_hot), .active(active), .slot(slot)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Channel c is visited in its own slot when its source bit is set
        assign stb[c] = active && (32'(slot) == c) && src_en[c];

        therm_mon_chan #(.CW(CW), .DBW(DBW)) chan_i (
            .clk(clk), .rst_n(rst_n), .stb(stb[c]), .code(codes[c]),
            .alm_thr(alm_thr[c]), .shut_thr(shut_thr[c]),
            .alm_deb(alm_deb), .shut_deb(shut_deb), .data_q(data_q[c]),
            .alm_evt(alm_evt[c]), .over_alm(over_alm[c]), .shut_hit(shut_hit[c])
        );
    end

    assign irq       = |(pend & irq_en);
    assign gpio_act  = |(shut_hit & gpio_en);
    assign shut_gpio = pol ? gpio_act : ~gpio_act;
    assign shut_req  = |(shut_hit & cru_en);

    // R3
    stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb));

    // R4
    alm_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & ~$past(pend))) |-> $past(|alm_evt));
endmodule

// File: tb/therm_mon_tb_top.sv
// Scoreboard bench: read tasks push expected values, a monitor pops and
// compares them against the registered read data.
module therm_mon_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NCH = 7;
    localparam int CW  = 12;
    localparam int P   = 40;

    localparam logic [11:0] R_CTRL = 12'h000, R_SRC = 12'h004, R_IRQ = 12'h008,
                            R_GPIO = 12'h00C, R_CRU = 12'h010, R_PEND = 12'h014,
                            R_ADEB = 12'h018, R_SDEB = 12'h01C, R_PER = 12'h020,
                            R_PERH = 12'h024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0][CW-1:0] samp = '0;
    logic irq, shut_gpio, shut_req;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_due = 1'b0;

    always #2.5 clk = ~clk;

    therm_mon dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .samp_code(samp), .irq(irq), .shut_gpio(shut_gpio), .shut_req(shut_req)
    );

    function automatic logic [11:0] ch_addr(input int blk, input int c);
        return 12'(blk * 64 + c * 4);
    endfunction

    always @(posedge clk) rd_due <= bus_sel && !bus_we;

    // Monitor: compare registered read data with the queued expectation
    always @(negedge clk) begin
        if (rd_due && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pin_chk(input logic act, input logic e, input string t);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: pin got %b expected %b", t, act, e);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Scanning on for n rounds of period P, then off while idle
    task automatic scan_rounds(input int n);
        bus_wr(R_CTRL, 32'h0001_0001);
        repeat (n * (P + NCH) + 4) @(negedge clk);
        bus_wr(R_CTRL, 32'h0001_0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        bus_rd(R_CTRL, 32'h0, "R1 ctrl");
        bus_rd(R_PEND, 32'h0, "R1 pend");
        bus_rd(R_ADEB, 32'h4, "R1 alarm debounce");
        bus_rd(R_SDEB, 32'h4, "R1 shutdown debounce");
        pin_chk(irq, 1'b0, "R1 irq");
        pin_chk(shut_gpio, 1'b1, "R1 shut_gpio");
        pin_chk(shut_req, 1'b0, "R1 shut_req");

        // R2 masked writes
        bus_wr(R_CTRL, 32'h0000_0101);
        bus_rd(R_CTRL, 32'h0, "R2 unmasked write ignored");
        bus_wr(R_CTRL, 32'h0100_0101);
        bus_rd(R_CTRL, 32'h100, "R2 polarity only");
        pin_chk(shut_gpio, 1'b0, "R9 active-high rests low");
        bus_wr(R_CTRL, 32'h0100_0000);
        pin_chk(shut_gpio, 1'b1, "R9 active-low rests high");
        bus_wr(R_SRC, 32'h007F_0055);
        bus_rd(R_SRC, 32'h55, "R2 src enable");
        bus_wr(R_SRC, 32'h0002_FFFF);
        bus_rd(R_SRC, 32'h57, "R2 src single bit");

        // Configuration
        bus_wr(R_PER, P);
        bus_wr(R_PERH, P);
        bus_wr(R_SDEB, 32'd2);
        for (int c = 0; c < NCH; c++) begin
            bus_wr(ch_addr(2, c), 32'h800);
            bus_wr(ch_addr(3, c), 32'hF00);
        end
        bus_wr(R_IRQ, 32'h0002_0002);
        bus_wr(R_GPIO, 32'h0010_0010);
        samp[0] = 12'h100; samp[1] = 12'h900; samp[2] = 12'h850;
        samp[3] = 12'h333; samp[4] = 12'hF10; samp[5] = 12'h444; samp[6] = 12'h200;

        scan_rounds(1);
        bus_rd(ch_addr(1, 0), 32'h100, "R3 data ch0");
        bus_rd(ch_addr(1, 1), 32'h900, "R3 data ch1");
        bus_rd(ch_addr(1, 3), 32'h0, "R3 disabled ch3 holds");
        bus_rd(ch_addr(1, 4), 32'hF10, "R3 data ch4");
        bus_rd(R_PEND, 32'h0, "R4 debounce not met");
        pin_chk(shut_gpio, 1'b1, "R7 shutdown debounce not met");

        scan_rounds(1);
        pin_chk(shut_gpio, 1'b0, "R8 gpio shutdown active-low");
        pin_chk(shut_req, 1'b0, "R8 no clk/reset route");
        bus_wr(R_CRU, 32'h0010_0010);
        pin_chk(shut_req, 1'b1, "R8 clk/reset route");

        samp[2] = 12'h700;
        scan_rounds(1);
        samp[2] = 12'h850;
        scan_rounds(1);
        bus_rd(R_PEND, 32'h12, "R4 pending after debounce, ch2 run broken");
        pin_chk(irq, 1'b1, "R6 irq ch1");

        bus_wr(R_PEND, 32'h2);
        bus_rd(R_PEND, 32'h10, "R5 W1C ch1");
        pin_chk(irq, 1'b0, "R6 irq masked ch4");

        samp[1] = 12'h100; samp[4] = 12'h100;
        scan_rounds(1);
        bus_rd(R_PEND, 32'h10, "R5 pending sticky after drop");
        bus_rd(ch_addr(1, 4), 32'h100, "R3 data ch4 lowered");
        pin_chk(shut_gpio, 1'b0, "R7 shutdown sticky");
        bus_wr(R_IRQ, 32'h0010_0010);
        pin_chk(irq, 1'b1, "R6 irq enable ch4");
        bus_wr(R_PEND, 32'h10);
        pin_chk(irq, 1'b0, "R5 W1C ch4 clears irq");
        bus_wr(R_CTRL, 32'h0100_0100);
        pin_chk(shut_gpio, 1'b1, "R9 active-high asserted");

        // R10 hot interval
        samp = '0;
        do_reset();
        bus_wr(R_PER, 32'd200);
        bus_wr(R_PERH, 32'd20);
        bus_wr(R_SRC, 32'h0001_0001);
        bus_wr(ch_addr(2, 0), 32'h800);
        samp[0] = 12'h900;
        bus_wr(R_CTRL, 32'h0001_0001);
        repeat (100) @(negedge clk);
        bus_rd(ch_addr(1, 0), 32'h0, "R3 no sample before period");
        repeat (109) @(negedge clk);
        samp[0] = 12'h901;
        repeat (15) @(negedge clk);
        bus_rd(ch_addr(1, 0), 32'h900, "R10 before hot round");
        repeat (14) @(negedge clk);
        bus_rd(ch_addr(1, 0), 32'h901, "R10 hot round sampled");
        bus_wr(R_CTRL, 32'h0001_0000);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule